// File: doc/BRIEF.md
# Translation and Exception Control Register Bank

This block holds the software-visible control words that a processor's page-table walker and exception logic consult. It sits on a simple single-cycle register bus and stores eight 32-bit registers:

- the high, low and assistance words of a page-table entry;
- the translation table base;
- the faulting address;
- the trap number;
- the exception event code and the interrupt event code.

Each register keeps only the bits that are legal for it. The bits it drops always read back as zero.

The low byte of the entry-high register is the address-space identifier. When a write to that register carries a new identifier, the block raises a one-cycle TLB flush request toward the translation hardware. The identifier is new when its low byte differs from the byte already held. The TLB itself and the translation are outside this block. A bus access to an offset that maps to no register reads zero and raises an error flag for one cycle.

Top module: `mmu_exc_regs`

## Requirements
- R1: After reset every register holds zero, and `rdata`, `acc_err` and `tlb_flush` are zero.
- R2: The register map uses byte offsets, and every register is word aligned:

  | Offset | Register | Legal bits |
  |---|---|---|
  | 0x00 | entry-high | all 32 bits |
  | 0x04 | entry-low | all 32 bits |
  | 0x08 | entry-assist | bits 3:0 |
  | 0x0C | table base | all 32 bits |
  | 0x10 | fault address | all 32 bits |
  | 0x14 | trap number | bits 10:0 |
  | 0x18 | exception event | bits 10:0 |
  | 0x1C | interrupt event | bits 10:0 |

- R3: A write to entry-high whose bits 7:0 differ from the stored bits 7:0 raises `tlb_flush` in the cycle after the write. A write with equal bits 7:0 does not raise it.
- R4: `tlb_flush` is high for exactly one cycle per qualifying write.
- R5: Entry-low, table base and fault address store and return all 32 written bits. Entry-high also stores all 32 bits after every write, whether or not a flush is raised.
- R6: Entry-assist keeps only written bits 3:0. Bits 31:4 always read back as zero.
- R7: Trap number, exception event and interrupt event each keep only written bits 10:0. Bits 31:11 always read back as zero.
- R8: A read (`rd_en` high) returns its data on `rdata` in the next cycle. In a cycle that follows no read, `rdata` is zero.
- R9: An access is undecoded when `addr[1:0]` is not 0 or when the offset is 0x20 or above. An undecoded read returns zero. Any undecoded read or write pulses `acc_err` in the next cycle, and an undecoded write changes no register.
- R10: When `rd_en` and `wr_en` are both high for the same register, the read returns the value held before that write. The write still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read request this cycle |
| wr_en | input | 1 | Write request this cycle |
| addr | input | 6 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after `rd_en` |
| acc_err | output | 1 | One-cycle pulse for an undecoded access |
| tlb_flush | output | 1 | One-cycle TLB flush request on identifier change |

## Verification
The bench builds the block with its default parameters. These are a 6-bit offset, 32-bit data, a 4-bit assistance field and 11-bit event codes. With a 6-bit offset the whole address space is 64 byte offsets, so every decoded and every undecoded offset is swept. Each register is written with all-ones, alternating and walking-one patterns so that every kept and dropped bit position is observed. A sequence of entry-high writes with repeating and changing identifiers covers both the flush and the no-flush outcomes, and the cycle that follows each of them.

// File: rtl/mer_pkg.sv
`timescale 1ns/1ps
package mer_pkg;
    localparam int NUM_REGS = 8;
    localparam int IDX_W    = $clog2(NUM_REGS);

    typedef enum logic [IDX_W-1:0] {
        IDX_ENT_HI  = 3'd0,
        IDX_ENT_LO  = 3'd1,
        IDX_ASSIST  = 3'd2,
        IDX_TBASE   = 3'd3,
        IDX_FADDR   = 3'd4,
        IDX_TRAP    = 3'd5,
        IDX_EXCEVT  = 3'd6,
        IDX_IRQEVT  = 3'd7
    } reg_idx_e;

    // number of legal low bits held by each register
    function automatic int keep_width(input int idx, input int data_w,
                                      input int assist_w, input int evt_w);
        if (idx == int'(IDX_ASSIST))
            return assist_w;
        if (idx == int'(IDX_TRAP) || idx == int'(IDX_EXCEVT) || idx == int'(IDX_IRQEVT))
            return evt_w;
        return data_w;
    endfunction
endpackage

// File: rtl/mer_decode.sv
`timescale 1ns/1ps
module mer_decode #(
    parameter int ADDR_W = 6,
    parameter int NUM    = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NUM-1:0]    sel,
    output logic              hit
);
    localparam int WORD_W = ADDR_W - 2;

    logic              aligned;
    logic [WORD_W-1:0] word;

    assign aligned = (addr[1:0] == 2'b00);
    assign word    = addr[ADDR_W-1:2];

    for (genvar i = 0; i < NUM; i++) begin : g_sel
        assign sel[i] = aligned && (word == WORD_W'(i));
    end

    assign hit = |sel;
endmodule

// File: rtl/mer_reg.sv
`timescale 1ns/1ps
module mer_reg #(
    parameter int DATA_W = 32,
    parameter int KEEP_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    localparam logic [DATA_W-1:0] MASK = {DATA_W{1'b1}} >> (DATA_W - KEEP_W);

    logic [DATA_W-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (we)
            val_d = wdata & MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            val_q <= '0;
        else
            val_q <= val_d;
    end

    assign q = val_q;
endmodule

// File: rtl/mer_rdmux.sv
`timescale 1ns/1ps
module mer_rdmux #(
    parameter int DATA_W = 32,
    parameter int NUM    = 8
) (
    input  logic [NUM-1:0][DATA_W-1:0] vals,
    input  logic [NUM-1:0]             sel,
    output logic [DATA_W-1:0]          data
);
    always_comb begin
        data = '0;
        for (int i = 0; i < NUM; i++)
            data = data | (vals[i] & {DATA_W{sel[i]}});
    end
endmodule

// File: rtl/mmu_exc_regs.sv
`timescale 1ns/1ps
module mmu_exc_regs
    import mer_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 6,
    parameter int ASID_W   = 8,
    parameter int ASSIST_W = 4,
    parameter int EVT_W    = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              acc_err,
    output logic              tlb_flush
);
    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              err;
        logic              flush;
    } resp_t;

    logic [NUM_REGS-1:0]             sel;
    logic                            hit;
    logic [NUM_REGS-1:0][DATA_W-1:0] vals;
    logic [DATA_W-1:0]               mux_data;
    logic                            asid_new;
    resp_t                           resp_d, resp_q;

    mer_decode #(.ADDR_W(ADDR_W), .NUM(NUM_REGS)) u_dec (
        .addr (addr),
        .sel  (sel),
        .hit  (hit)
    );

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        mer_reg #(
            .DATA_W (DATA_W),
            .KEEP_W (keep_width(i, DATA_W, ASSIST_W, EVT_W))
        ) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wr_en && sel[i]),
            .wdata (wdata),
            .q     (vals[i])
        );
    end

    mer_rdmux #(.DATA_W(DATA_W), .NUM(NUM_REGS)) u_mux (
        .vals (vals),
        .sel  (sel),
        .data (mux_data)
    );

    assign asid_new = (wdata[ASID_W-1:0] != vals[IDX_ENT_HI][ASID_W-1:0]);

    always_comb begin
        resp_d       = '0;
        resp_d.rdata = (rd_en && hit) ? mux_data : '0;
        resp_d.err   = (rd_en || wr_en) && !hit;
        resp_d.flush = wr_en && sel[IDX_ENT_HI] && asid_new;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            resp_q <= '0;
        else
            resp_q <= resp_d;
    end

    assign rdata     = resp_q.rdata;
    assign acc_err   = resp_q.err;
    assign tlb_flush = resp_q.flush;
endmodule

// File: rtl/mer_chk.sv
`timescale 1ns/1ps
module mer_chk #(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 6,
    parameter int ASSIST_W = 4,
    parameter int EVT_W    = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] rdata,
    input logic              acc_err,
    input logic              tlb_flush
);
    p_flush_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_flush |-> $past(wr_en && addr == ADDR_W'(0)));

    p_flush_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tlb_flush && !wr_en) |=> !tlb_flush);

    p_assist_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_en) && $past(addr) == ADDR_W'(8)) |-> rdata[DATA_W-1:ASSIST_W] == '0);

    p_evt_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_en) && ($past(addr) == ADDR_W'(20) || $past(addr) == ADDR_W'(24) ||
                          $past(addr) == ADDR_W'(28))) |-> rdata[DATA_W-1:EVT_W] == '0);

    p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_en) |-> rdata == '0);

    p_err_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> $past(rd_en || wr_en));

    p_err_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_err && $past(rd_en)) |-> rdata == '0);
endmodule

bind mmu_exc_regs mer_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ASSIST_W(ASSIST_W), .EVT_W(EVT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .rdata(rdata), .acc_err(acc_err), .tlb_flush(tlb_flush)
);

// File: tb/sim_mmu_exc_regs.sv
`timescale 1ns/1ps
module sim_mmu_exc_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        acc_err;
    logic        tlb_flush;

    int checks = 0;
    int fails  = 0;
    logic [31:0] model [8];
    logic [31:0] got_d;
    logic        got_e, got_f;

    always #2.5 clk = ~clk;

    mmu_exc_regs u0 (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .acc_err(acc_err), .tlb_flush(tlb_flush)
    );

    function automatic logic [31:0] mask_for(input int idx);
        if (idx == 2) return 32'h0000_000F;
        if (idx >= 5) return 32'h0000_07FF;
        return 32'hFFFF_FFFF;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic rd, input logic wr, input logic [5:0] a,
                          input logic [31:0] d);
        @(negedge clk);
        rd_en = rd; wr_en = wr; addr = a; wdata = d;
        @(posedge clk); #1;
        got_d = rdata; got_e = acc_err; got_f = tlb_flush;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    endtask

    task automatic wr_model(input int idx, input logic [31:0] d);
        access(1'b0, 1'b1, 6'(idx * 4), d);
        model[idx] = d & mask_for(idx);
    endtask

    task automatic verify_all(input string req);
        for (int i = 0; i < 8; i++) begin
            access(1'b1, 1'b0, 6'(i * 4), '0);
            check(req, got_d, model[i]);
        end
    endtask

    initial begin
        #500000;
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] pats [6];
        pats[0] = 32'hFFFF_FFFF; pats[1] = 32'hA5A5_A5A5; pats[2] = 32'h5A5A_5A5A;
        pats[3] = 32'h0000_0000; pats[4] = 32'h8000_0001; pats[5] = 32'h1234_5678;
        for (int i = 0; i < 8; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 rdata", rdata, 0);
        check("R1 acc_err", 32'(acc_err), 0);
        check("R1 tlb_flush", 32'(tlb_flush), 0);
        @(negedge clk); rst_n = 1'b1;
        verify_all("R1 reset value");

        // R2 R5 R6 R7: pattern sweeps, including walking ones
        for (int i = 0; i < 8; i++) begin
            for (int p = 0; p < 6; p++) begin
                wr_model(i, pats[p]);
                access(1'b1, 1'b0, 6'(i * 4), '0);
                check(i == 2 ? "R6 assist width" : (i >= 5 ? "R7 event width" : "R5 full width"),
                      got_d, model[i]);
            end
            for (int b = 0; b < 32; b++) begin
                wr_model(i, 32'h1 << b);
                access(1'b1, 1'b0, 6'(i * 4), '0);
                check("R2 walking one", got_d, model[i]);
            end
        end
        verify_all("R2 map isolation");

        // R3 R4: flush on identifier change
        wr_model(0, 32'h0);
        for (int k = 0; k < 32; k++) begin
            logic [31:0] v;
            logic        expf;
            v = {24'(k * 32'h9E3779), 8'((k / 2) * 37)};
            expf = (v[7:0] != model[0][7:0]);
            access(1'b0, 1'b1, 6'h00, v);
            check("R3 flush", 32'(got_f), 32'(expf));
            model[0] = v;
            @(posedge clk); #1;
            check("R4 single pulse", 32'(tlb_flush), 0);
            access(1'b1, 1'b0, 6'h00, '0);
            check("R5 entry-high stored", got_d, v);
            check("R3 no flush on read", 32'(got_f), 0);
        end

        // R8: idle cycle returns zero
        @(posedge clk); #1;
        check("R8 idle rdata", rdata, 0);

        // R9: undecoded offsets
        for (int a = 0; a < 64; a++) begin
            if (a[1:0] != 2'b00 || a >= 32) begin
                access(1'b1, 1'b0, 6'(a), '0);
                check("R9 read zero", got_d, 0);
                check("R9 read err", 32'(got_e), 1);
                access(1'b0, 1'b1, 6'(a), 32'hFFFF_FFFF);
                check("R9 write err", 32'(got_e), 1);
                check("R9 write no flush", 32'(got_f), 0);
            end else begin
                access(1'b1, 1'b0, 6'(a), '0);
                check("R9 decoded no err", 32'(got_e), 0);
            end
        end
        verify_all("R9 writes ignored");

        // R10: read and write in the same cycle
        for (int i = 0; i < 8; i++) begin
            logic [31:0] nv;
            nv = 32'hC3C3_0000 | 32'(i * 16 + 5);
            access(1'b1, 1'b1, 6'(i * 4), nv);
            check("R10 old value", got_d, model[i]);
            model[i] = nv & mask_for(i);
            access(1'b1, 1'b0, 6'(i * 4), '0);
            check("R10 new value", got_d, model[i]);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule